// File: doc/BRIEF.md
# Serially Configured Lookup-Table Logic Cell

This block is one programmable logic element of the kind tiled across a reconfigurable fabric. It holds a K-input lookup table, a D flip-flop behind it and an output selector, and none of its behaviour is fixed when it is built. After reset the cell is blank. A configuration stream is shifted in one bit per clock. Once the whole stream is in, the K logic inputs address the table. The cell output is then either the addressed table bit taken straight through, or that bit after the flip-flop.

The configuration sits in volatile storage. Any reset wipes it, and the cell must be loaded again before it does anything useful. A blank or partly loaded cell drives its output low, and its flip-flop captures nothing. After a cell has taken its own bits, it passes further stream bits to a pass-through output one cycle later. Cells wired in a row can therefore share one stream: the first bits of the stream land in the first cell.

A loader state machine controls the load. It has three states:
- `LD_EMPTY`: nothing has been received yet.
- `LD_SHIFT`: a partial stream is held.
- `LD_READY`: the configuration is complete.

It has three transitions:
- The first enabled bit moves `LD_EMPTY` to `LD_SHIFT`.
- The last enabled bit moves `LD_SHIFT` to `LD_READY`.
- Reset returns any state to `LD_EMPTY`.

`LD_READY` has no way out except reset.

Top module: `lutcell_top`

## Requirements
- R1: After reset, `cfg_done` is 0, `cell_out` is 0 and `cfg_dout` is 0.
- R2: On each clock edge where `cfg_en` is 1 and loading is not finished, one bit of `cfg_din` is taken. Edges with `cfg_en` at 0 take nothing. `cfg_done` rises on the cycle after the edge that takes bit number 2^K+2, and it stays 1 until reset.
- R3: Stream order is as follows. The first bit is the output select: 1 means registered and 0 means direct. The second bit is the clear enable. Then come the 2^K table entries, from address 2^K-1 down to address 0.
- R4: In direct mode, `cell_out` equals the table entry at address `lut_in`, with no clock delay. `lut_in[K-1]` is the address MSB. For K=2, with A=`lut_in[1]` and B=`lut_in[0]`, the entries listed for AB = 00, 01, 10, 11 as 0001, 0111, 0110 and 1110 give AND, OR, XOR and NAND.
- R5: In registered mode, `cell_out` equals the table entry addressed by the `lut_in` value sampled at the previous clock edge.
- R6: When the clear enable is 1, an edge with `ff_clr` at 1 loads 0 into the flip-flop. When the clear enable is 0, `ff_clr` has no effect.
- R7: While `cfg_done` is 0, `cell_out` is 0 and the flip-flop does not capture. The first capture happens at the first edge at which `cfg_done` is already 1. In registered mode, the first cycle with `cfg_done` high therefore shows 0.
- R8: While loading is in progress, `cfg_dout` is 0. After `cfg_done`, an edge with `cfg_en` at 1 presents the sampled `cfg_din` on `cfg_dout`, and an edge with `cfg_en` at 0 presents 0.
- R9: Bits shifted in after `cfg_done` do not change the table or the mode bits.
- R10: A reset in the middle of operation erases the configuration. The cell reads as blank until a full stream is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading and for the flip-flop |
| rst_n | input | 1 | Active-low synchronous reset; erases the configuration |
| cfg_en | input | 1 | Qualifies `cfg_din` on each edge |
| cfg_din | input | 1 | Serial configuration data |
| cfg_dout | output | 1 | Pass-through of surplus stream bits to the next cell |
| cfg_done | output | 1 | High once the full configuration is held |
| lut_in | input | K | Table address / logic inputs |
| ff_clr | input | 1 | Synchronous clear request for the flip-flop |
| cell_out | output | 1 | Cell output |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is low at the first edge, so every state register starts from a known value.
- `cfg_en`, `cfg_din`, `lut_in` and `ff_clr` change only away from the rising edge.

The stimulus meets both assumptions. It holds reset from time zero and drives every input on the falling edge. It loads each stream after a fresh reset, so each load starts from a blank cell. Gaps in `cfg_en` appear only inside streams whose expected completion cycle the bench counts itself.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_SHIFT = 2'd1,
        LD_READY = 2'd2
    } ld_state_e;

    localparam int CTRL_BITS = 2;

    function automatic int cfg_len(input int k);
        return (1 << k) + CTRL_BITS;
    endfunction

endpackage

// File: rtl/lutcell_loader.sv
module lutcell_loader
    import lutcell_pkg::*;
#(
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_dout,
    output logic             ready,
    output logic [CFG_W-1:0] cfg_bits
);

    localparam int CW = $clog2(CFG_W + 1);
    localparam logic [CW-1:0] LAST = CW'(CFG_W - 1);

    ld_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           shift_en;
    logic           pass_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY: if (cfg_en) state_d = LD_SHIFT;
            LD_SHIFT: if (cfg_en && cnt_q == LAST) state_d = LD_READY;
            LD_READY: state_d = LD_READY;
            default:  state_d = LD_EMPTY;
        endcase
    end

    // state-derived outputs
    always_comb begin
        ready    = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            LD_EMPTY: shift_en = cfg_en;
            LD_SHIFT: shift_en = cfg_en;
            LD_READY: ready    = 1'b1;
            default:  shift_en = 1'b0;
        endcase
    end

    // volatile configuration store and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_bits <= '0;
            cnt_q    <= '0;
        end else if (shift_en) begin
            cfg_bits <= {cfg_bits[CFG_W-2:0], cfg_din};
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // surplus bits pass on once this cell is full
    always_ff @(posedge clk) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= (ready && cfg_en) ? cfg_din : 1'b0;
    end

    assign cfg_dout = pass_q;

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(cfg_bits));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !cfg_en) |=> $stable(cfg_bits));

endmodule

// File: rtl/lutcell_read.sv
module lutcell_read #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_i,
    input  logic [K-1:0]      addr_i,
    output logic              bit_o
);

    localparam int ENTRIES = 1 << K;

    logic [ENTRIES-1:0] hit;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign hit[i] = table_i[i] && (addr_i == K'(i));
    end

    assign bit_o = |hit;

endmodule

// File: rtl/lutcell_flop.sv
module lutcell_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic clr_req,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (cap_en)  q <= clr_req ? 1'b0 : d;
    end

    p_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && clr_req) |=> !q);

    p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !clr_req) |=> q == $past(d));

endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
    import lutcell_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic         cfg_dout,
    output logic         cfg_done,
    input  logic [K-1:0] lut_in,
    input  logic         ff_clr,
    output logic         cell_out
);

    localparam int ENTRIES = 1 << K;
    localparam int CFG_W   = cfg_len(K);
    localparam int SEL_POS = CFG_W - 1;
    localparam int CLR_POS = CFG_W - 2;

    logic [CFG_W-1:0]   cfg_bits;
    logic [ENTRIES-1:0] table_bits;
    logic               ready;
    logic               reg_mode;
    logic               clr_allow;
    logic               lut_bit;
    logic               ff_q;

    lutcell_loader #(.CFG_W(CFG_W)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_dout (cfg_dout),
        .ready    (ready),
        .cfg_bits (cfg_bits)
    );

    assign reg_mode   = cfg_bits[SEL_POS];
    assign clr_allow  = cfg_bits[CLR_POS];
    assign table_bits = cfg_bits[ENTRIES-1:0];

    lutcell_read #(.K(K)) u_read (
        .table_i (table_bits),
        .addr_i  (lut_in),
        .bit_o   (lut_bit)
    );

    lutcell_flop u_flop (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (ready),
        .clr_req (clr_allow && ff_clr),
        .d       (lut_bit),
        .q       (ff_q)
    );

    always_comb begin
        cell_out = 1'b0;
        if (ready) cell_out = reg_mode ? ff_q : lut_bit;
    end

    assign cfg_done = ready;

    p_blank_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !cell_out);

    p_pass_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_en) |=> cfg_dout == $past(cfg_din));

    p_quiet_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> !cfg_dout);

endmodule

// File: tb/test_lutcell_top.sv
module test_lutcell_top;

    localparam int K = 2;
    localparam int NB = (1 << K) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_dout;
    logic cfg_done;
    logic [K-1:0] lut_in = '0;
    logic ff_clr = 1'b0;
    logic cell_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lutcell_top #(.K(K)) i_lutcell_top (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .cfg_done(cfg_done), .lut_in(lut_in),
        .ff_clr(ff_clr), .cell_out(cell_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_en = 1'b0; ff_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // stream: select, clear enable, entries addr 3..0; gap inserts idle cycles
    task automatic load(input bit sel, input bit cen, input logic [3:0] tbl, input bit gap);
        logic [NB-1:0] s;
        s = {sel, cen, tbl[3], tbl[2], tbl[1], tbl[0]};
        for (int i = NB - 1; i >= 0; i--) begin
            @(negedge clk);
            if (gap && i == 2) begin
                cfg_en = 1'b0;
                @(negedge clk);
                @(negedge clk);
                #1 chk("R2 no count while disabled", cfg_done, 0);
                @(negedge clk);
            end
            cfg_en = 1'b1; cfg_din = s[i];
            #1;
            chk("R2 not done early", cfg_done, 0);
            chk("R8 dout quiet while loading", cfg_dout, 0);
            chk("R7 output low while blank", cell_out, 0);
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_din = 1'b0;
        #1 chk("R2 done after full stream", cfg_done, 1);
    endtask

    initial begin
        do_reset();
        chk("R1 done after reset", cfg_done, 0);
        chk("R1 out after reset", cell_out, 0);
        chk("R1 dout after reset", cfg_dout, 0);

        // R4 and R3: every table, every address, direct mode
        for (int t = 0; t < 16; t++) begin
            do_reset();
            load(1'b0, 1'b0, 4'(t), t == 5);
            for (int a = 0; a < 4; a++) begin
                @(negedge clk); lut_in = 2'(a); #1;
                chk("R4 direct read", cell_out, (t >> a) & 1);
            end
        end

        // R4 named gates, expected from boolean arithmetic
        begin
            logic [3:0] gates [4];
            gates[0] = 4'b1000; gates[1] = 4'b1110; gates[2] = 4'b0110; gates[3] = 4'b0111;
            for (int g = 0; g < 4; g++) begin
                do_reset();
                load(1'b0, 1'b0, gates[g], 1'b0);
                for (int a = 0; a < 4; a++) begin
                    int av, bv, e;
                    av = (a >> 1) & 1; bv = a & 1;
                    e = (g == 0) ? (av & bv) : (g == 1) ? (av | bv) :
                        (g == 2) ? (av ^ bv) : (1 - (av & bv));
                    @(negedge clk); lut_in = 2'(a); #1;
                    chk("R4 named gate", cell_out, e);
                end
            end
        end

        // R5 and R7: registered mode for every table
        for (int t = 0; t < 16; t++) begin
            do_reset();
            lut_in = 2'd3;
            load(1'b1, 1'b0, 4'(t), 1'b0);
            chk("R7 first done cycle shows no capture", cell_out, 0);
            for (int a = 0; a < 4; a++) begin
                @(negedge clk); lut_in = 2'(a); #1;
                chk("R5 registered holds previous", cell_out, (t >> ((a + 3) & 3)) & 1);
                @(negedge clk); #1;
                chk("R5 registered read", cell_out, (t >> a) & 1);
                lut_in = 2'((a + 1) & 3);
                lut_in = 2'(a);
            end
        end

        // R6: clear enabled then disabled
        for (int ce = 0; ce < 2; ce++) begin
            do_reset();
            load(1'b1, ce[0], 4'hF, 1'b0);
            @(negedge clk); #1;
            chk("R6 registered ones", cell_out, 1);
            ff_clr = 1'b1;
            @(negedge clk); #1;
            chk("R6 clear effect", cell_out, ce ? 0 : 1);
            ff_clr = 1'b0;
            @(negedge clk); #1;
            chk("R6 resumes after clear", cell_out, 1);
        end

        // R8 pass-through and R9 frozen configuration
        do_reset();
        load(1'b0, 1'b0, 4'b0110, 1'b0);
        for (int i = 0; i < 8; i++) begin
            bit b;
            b = ((8'b1011_0010 >> i) & 1) != 0;
            @(negedge clk); cfg_en = 1'b1; cfg_din = b; #1;
            @(negedge clk); cfg_en = (i % 2) == 0; #1;
            chk("R8 pass-through bit", cfg_dout, b);
        end
        @(negedge clk); cfg_en = 1'b0; cfg_din = 1'b1; #1;
        @(negedge clk); #1;
        chk("R8 zero when disabled", cfg_dout, 0);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); lut_in = 2'(a); #1;
            chk("R9 table unchanged", cell_out, (6 >> a) & 1);
        end
        chk("R9 still direct mode done", cfg_done, 1);

        // R10: reset erases configuration
        @(negedge clk); lut_in = 2'd1;
        do_reset();
        chk("R10 done cleared", cfg_done, 0);
        chk("R10 out blank", cell_out, 0);
        @(negedge clk); #1;
        chk("R10 still blank", cell_out, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule